// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This controller sits between a host and a byte-wide static memory and guards its contents while the supply is failing and coming back. Two digitized comparator flags arrive from the analog side: one says the supply is above the deselect threshold, the other says it is above the battery switchover threshold. The host's chip-enable, write-enable and output-enable requests pass through to the memory only while the supply is healthy and the recovery holdoff is over. At all other times the memory is deselected, write strobes are held off, and the data bus is left undriven.

A four-state machine (normal, protect, battery, recover) drives the gating. Both flags are resynchronized. The deselect flag also passes through a configurable delay, which models late engagement of protection when the supply collapses quickly. The battery switch is chosen only below the switchover threshold. When the supply returns, a cycle counter enforces the recovery holdoff, sized in clock cycles (100 000 cycles is 1 ms at 100 MHz). After that, the host must show chip-enable released at least once before any strobe is passed. This stops a chip-enable that was already held low during power-up from turning into a write.

All pins are plain level controls. No data stream passes through the block, so it has no valid/ready interface and no back-pressure.

Top module: `pfail_guard`

## Requirements
- R1: While reset is asserted and right after it, the block is in protect: `mem_ce_n`=1, `mem_we_n`=1, `dq_oe`=0, `batt_sel`=0, `mem_ready`=0. It leaves protect only through a full recovery interval.
- R2: When ready and armed, the memory strobes follow the host. `mem_ce_n` equals `host_ce_n`. `mem_we_n` is low exactly when both `host_ce_n` and `host_we_n` are low. `dq_oe` is high exactly when `host_ce_n` and `host_oe_n` are low and `host_we_n` is high, so a write always turns the bus around.
- R3: The deselect flag passes through two synchronizer flops and then `PROT_LAT` delay flops. A fall of `sup_ok_raw` driven between clock edges takes effect on the outputs at the (3+`PROT_LAT`)-th following rising edge, and not before.
- R4: Outside normal operation, `mem_ce_n`=1, `mem_we_n`=1 and `dq_oe`=0 whatever the host pins do.
- R5: A write in progress is cut in the same cycle that protection engages. No further write strobe reaches the memory until normal operation is re-entered and re-armed, so only the location being written can be disturbed.
- R6: In protect, a low `sup_live_raw` selects the battery (`batt_sel`=1) at the third rising edge after the change. When it returns high, `batt_sel` drops at the third edge and the block goes back to protect. The battery state is entered only from protect.
- R7: Once the delayed deselect flag is high in protect, the block spends exactly `RECOV_CYC` cycles in recover before `mem_ready` rises.
- R8: A deselect-flag drop during recover returns the block to protect. The next recovery counts a full `RECOV_CYC` cycles again.
- R9: On entry to normal, host strobes are ignored until `host_ce_n` has been sampled high at a rising edge in normal. A chip-enable held low through recovery therefore never produces a write.
- R10: `mem_ready` is high only in the normal state, and never together with `batt_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_ok_raw | input | 1 | Asynchronous flag, supply above deselect threshold |
| sup_live_raw | input | 1 | Asynchronous flag, supply above battery switchover threshold |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| mem_ce_n | output | 1 | Gated chip enable to memory, active low |
| mem_we_n | output | 1 | Gated write enable to memory, active low |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| batt_sel | output | 1 | Select battery supply |
| mem_ready | output | 1 | High only in normal operation |

## Verification
The gating is exercised with reads, writes, output-disabled selects and deselects, each in the healthy state and again after protection has engaged. This shows pass-through apart from forced inactivity. A supply drop is applied in the middle of a write and sampled one edge before and at the predicted engagement edge, which separates correct synchronizer and latency depth from a stage too few or too many. A recovery is aborted part way and then restarted, so a counter that fails to clear shows up as early readiness. Chip-enable is held low through recovery, which tells the arming rule apart from plain state gating.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BATTERY = 2'd2,
    ST_RECOVER = 2'd3
  } pfg_state_t;

  localparam int unsigned FLAG_OK   = 0;
  localparam int unsigned FLAG_LIVE = 1;
  localparam int unsigned NUM_FLAGS = 2;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= RST_VAL;
    else        pipe[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/pfg_delay.sv
module pfg_delay #(
  parameter int unsigned DEPTH = 0,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  if (DEPTH == 0) begin : g_bypass
    assign q = d;
  end else begin : g_shift
    logic [DEPTH-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {DEPTH{RST_VAL}};
      else if (DEPTH == 1) sr[0] <= d;
      else sr <= {sr[DEPTH-2:0], d};
    end
    assign q = sr[DEPTH-1];
  end
endmodule

// File: rtl/pfg_recov_timer.sv
module pfg_recov_timer #(
  parameter int unsigned COUNT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PROT_LAT    = 0,
  parameter int unsigned RECOV_CYC   = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_ok_raw,
  input  logic sup_live_raw,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic dq_oe,
  output logic batt_sel,
  output logic mem_ready
);
  localparam logic [NUM_FLAGS-1:0] SYNC_RST = NUM_FLAGS'(1) << FLAG_LIVE;

  logic [NUM_FLAGS-1:0] flags_raw;
  logic [NUM_FLAGS-1:0] flags_s;
  logic                 ok_lat;
  logic                 live_s;
  logic                 rec_done;
  logic                 armed_q;
  logic                 pass;
  pfg_state_t           state_q;
  pfg_state_t           state_d;

  assign flags_raw[FLAG_OK]   = sup_ok_raw;
  assign flags_raw[FLAG_LIVE] = sup_live_raw;

  pfg_sync #(
    .WIDTH  (NUM_FLAGS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(flags_raw),
    .q_sync (flags_s)
  );

  pfg_delay #(
    .DEPTH  (PROT_LAT),
    .RST_VAL(1'b0)
  ) u_lat (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (flags_s[FLAG_OK]),
    .q    (ok_lat)
  );

  assign live_s = flags_s[FLAG_LIVE];

  pfg_recov_timer #(
    .COUNT(RECOV_CYC)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (state_q == ST_RECOVER),
    .done (rec_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL:  if (!ok_lat) state_d = ST_PROTECT;
      ST_PROTECT: begin
        if (!live_s)     state_d = ST_BATTERY;
        else if (ok_lat) state_d = ST_RECOVER;
      end
      ST_BATTERY: if (live_s) state_d = ST_PROTECT;
      ST_RECOVER: begin
        if (!ok_lat)       state_d = ST_PROTECT;
        else if (rec_done) state_d = ST_NORMAL;
      end
      default: state_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PROTECT;
    else        state_q <= state_d;
  end

  // Arm only after chip enable has been seen released inside normal.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed_q <= 1'b0;
    else if (state_q != ST_NORMAL) armed_q <= 1'b0;
    else if (host_ce_n)           armed_q <= 1'b1;
  end

  assign pass      = (state_q == ST_NORMAL) && armed_q;
  assign mem_ce_n  = !(pass && !host_ce_n);
  assign mem_we_n  = !(pass && !host_ce_n && !host_we_n);
  assign dq_oe     = pass && !host_ce_n && !host_oe_n && host_we_n;
  assign batt_sel  = (state_q == ST_BATTERY);
  assign mem_ready = (state_q == ST_NORMAL);
endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk
  import pfg_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 100000
) (
  input logic       clk,
  input logic       rst_n,
  input pfg_state_t st,
  input logic       ok_q,
  input logic       mem_ce_n,
  input logic       mem_we_n,
  input logic       dq_oe,
  input logic       batt_sel,
  input logic       mem_ready
);
  localparam int unsigned RW = $clog2(RECOV_CYC + 2) + 1;
  localparam logic [RW-1:0] RMAX = RW'(RECOV_CYC + 1);

  logic [RW-1:0] rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rec_run <= '0;
    else if (st != ST_RECOVER)  rec_run <= '0;
    else if (rec_run != RMAX)   rec_run <= rec_run + 1'b1;
  end

  a_r4_gated_when_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> (mem_ce_n && mem_we_n && !dq_oe));

  a_r3_fail_engages: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_NORMAL && !ok_q) |=> (st == ST_PROTECT));

  a_r6_battery_from_protect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(batt_sel) |-> ($past(st) == ST_PROTECT));

  a_r7_full_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (rec_run == RW'(RECOV_CYC)));

  a_r8_recover_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECOVER && !ok_q) |=> (st == ST_PROTECT));

  a_r9_no_strobe_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (mem_ce_n && mem_we_n));

  a_r10_ready_excl_battery: assert property (@(posedge clk) disable iff (!rst_n)
    !(batt_sel && mem_ready));
endmodule

bind pfail_guard pfail_guard_chk #(.RECOV_CYC(RECOV_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .st       (state_q),
  .ok_q     (ok_lat),
  .mem_ce_n (mem_ce_n),
  .mem_we_n (mem_we_n),
  .dq_oe    (dq_oe),
  .batt_sel (batt_sel),
  .mem_ready(mem_ready)
);

// File: tb/sim_pfail_guard.sv
`timescale 1ns/1ps
module sim_pfail_guard;
  localparam int unsigned LAT = 2;
  localparam int unsigned REC = 16;
  localparam int unsigned ENG = 3 + LAT;   // edges from flag change to state change

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_ok_raw = 1'b1, sup_live_raw = 1'b1;
  logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
  logic mem_ce_n, mem_we_n, dq_oe, batt_sel, mem_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pfail_guard #(.SYNC_STAGES(2), .PROT_LAT(LAT), .RECOV_CYC(REC)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_ok_raw(sup_ok_raw), .sup_live_raw(sup_live_raw),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .dq_oe(dq_oe),
    .batt_sel(batt_sel), .mem_ready(mem_ready)
  );

  // Packed as {ce_n, we_n, oe, batt, ready}
  localparam logic [4:0] O_IDLE_PROT = 5'b11000;
  localparam logic [4:0] O_BATT      = 5'b11010;
  localparam logic [4:0] O_IDLE_RDY  = 5'b11001;
  localparam logic [4:0] O_READ      = 5'b01101;
  localparam logic [4:0] O_WRITE     = 5'b00001;
  localparam logic [4:0] O_SELNOOE   = 5'b01001;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host(input logic ce, input logic we, input logic oe);
    host_ce_n = ce; host_we_n = we; host_oe_n = oe;
    #1;
  endtask

  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {mem_ce_n, mem_we_n, dq_oe, batt_sel, mem_ready};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs {ce_n,we_n,oe,batt,rdy} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    host(1, 1, 1);
    tick(3);
    chk("R1 in reset", O_IDLE_PROT);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after reset", O_IDLE_PROT);
    tick(ENG + REC - 2);
    chk("R7 last recovery cycle", O_IDLE_PROT);
    tick(1);
    chk("R7 ready after recovery", O_IDLE_RDY);
    tick(1);
  endtask

  task automatic t_access;
    host(0, 1, 0); chk("R2 read", O_READ);
    host(0, 0, 0); chk("R2 write turns bus", O_WRITE);
    host(0, 0, 1); chk("R2 write", O_WRITE);
    host(0, 1, 1); chk("R2 select no oe", O_SELNOOE);
    host(1, 0, 0); chk("R2 deselect", O_IDLE_RDY);
  endtask

  task automatic t_fail_in_write;
    host(0, 0, 1);
    chk("R2 write before fail", O_WRITE);
    sup_ok_raw = 1'b0;
    tick(ENG - 1);
    chk("R3 one edge before engage", O_WRITE);
    tick(1);
    chk("R5 write cut at engage", O_IDLE_PROT);
    host(0, 1, 0); chk("R4 read ignored", O_IDLE_PROT);
    host(0, 0, 0); chk("R4 write ignored", O_IDLE_PROT);
    tick(3);
    chk("R5 no later strobe", O_IDLE_PROT);
  endtask

  task automatic t_battery;
    sup_live_raw = 1'b0;
    tick(2);
    chk("R6 before switchover", O_IDLE_PROT);
    tick(1);
    chk("R6 battery selected", O_BATT);
    host(0, 0, 0); chk("R4 battery gating", O_BATT);
    sup_live_raw = 1'b1;
    tick(2);
    chk("R6 battery held", O_BATT);
    tick(1);
    chk("R6 battery released", O_IDLE_PROT);
  endtask

  task automatic t_recover_abort_and_arm;
    host(0, 0, 1);                     // chip enable held low across power-up
    sup_ok_raw = 1'b1;
    tick(ENG + 5);
    chk("R8 mid recovery", O_IDLE_PROT);
    sup_ok_raw = 1'b0;
    tick(ENG);
    chk("R8 back in protect", O_IDLE_PROT);
    sup_ok_raw = 1'b1;
    tick(ENG + REC - 1);
    chk("R8 count restarted", O_IDLE_PROT);
    tick(1);
    chk("R9 ready but not armed", O_IDLE_RDY);
    tick(3);
    chk("R9 held chip enable ignored", O_IDLE_RDY);
    host(1, 0, 1);
    tick(1);
    host(0, 0, 1);
    chk("R9 write after arming", O_WRITE);
    host(1, 1, 1);
    chk("R10 ready in normal", O_IDLE_RDY);
  endtask

  initial begin
    t_reset;
    t_access;
    t_fail_in_write;
    t_battery;
    t_recover_abort_and_arm;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule